// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a memory-mapped watchdog. A 16-bit up-counter advances once per prescaled tick, with the ratio chosen by a 3-bit code. Software programs a timeout of N ticks by loading 65536 − N into the counter and then setting the enable bit. If software does not reload the counter in time, the counter wraps from 0xFFFF to 0. The block then raises a reset request for a fixed number of cycles and sets a sticky overflow flag.

Every register write must carry a per-register key in its upper data bits. A write with a wrong key is dropped without any effect. After each accepted write, a busy flag stays high for a fixed number of cycles, and software polls it before it enables the timer. The overflow flag and the reset-request pulse are cleared only by the power-on reset `por`. The system reset `rst` clears every other register, so after a restart software can still see that the last reset came from the watchdog.

The bus is 32 bits wide. A write is accepted in the cycle where `we` is high. Read data is registered: `rdata` shows the register selected by `addr` one cycle after that address is presented.

Top module: `keyed_wdt`

## Requirements
- R1: After `por`, the counter, the control/status register, the second control register and `reset_req` all read 0. After `rst`, every register except the overflow flag reads 0.
- R2: A write to offset 0 whose bits [31:16] equal 0x5A5A loads bits [15:0] into the counter.
- R3: A write to offset 4 or offset 8 whose bits [31:8] equal 0xA5A5A5 stores bits [7:0] into that register.
- R4: A write whose key does not match its offset changes no register, no flag and no busy state.
- R5: The status register at offset 4 reads as: enable at bit 7, busy at bit 5 (read-only), overflow at bit 4, and the prescaler code at bits [2:0]. Bits 6 and 3 read 0. Unmapped offsets read 0. `rdata` reflects the register state one cycle after `addr` is presented.
- R6: The busy bit reads 1 for exactly 3 cycles after each accepted write, and 0 otherwise.
- R7: Prescaler codes 0 to 7 select the division ratios 1, 4, 16, 32, 64, 128, 1024 and 4096 respectively. A counter load restarts the prescaler phase.
- R8: While the enable bit is 0, the counter and the prescaler hold their values.
- R9: When the enabled counter wraps from 0xFFFF to 0, `reset_req` goes high in the next cycle for exactly 16 cycles and the overflow flag is set.
- R10: The overflow flag survives `rst`. It is cleared by `por`, or by a keyed write to offset 4 with bit 4 at 0. A keyed write with bit 4 at 1 does not set it.
- R11: The register at offset 8 holds its 8-bit value and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| rst | input | 1 | Synchronous system reset, active high; keeps the overflow flag and the reset pulse |
| we | input | 1 | Write strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data: key in the upper bits, value in the lower bits |
| rdata | output | 32 | Registered read data of the register at `addr` |
| reset_req | output | 1 | Reset request raised after a watchdog timeout |

## Verification
A wrong key decode shows up within one read as a register that changed when it should not have, or failed to change when it should. A wrong busy count shows as a busy bit that drops one read too early or too late in a series of back-to-back status reads. A wrong prescaler ratio or a wrong wrap point moves the rising edge of `reset_req` away from the exact cycle implied by the preload and the ratio; for ratio 4096 the shift appears only after a full tick. A flag kept in the wrong reset domain is exposed by the first status read after `rst` or after `por`.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int BUS_W    = 32;
  localparam int OFS_CNT  = 0;
  localparam int OFS_CSA  = 4;
  localparam int OFS_CSB  = 8;
  localparam logic [15:0] KEY_CNT = 16'h5A5A;
  localparam logic [23:0] KEY_CTL = 24'hA5A5A5;
  localparam int B_EN   = 7;
  localparam int B_BUSY = 5;
  localparam int B_OVF  = 4;

  function automatic int unsigned div_ratio(input logic [2:0] code);
    case (code)
      3'd0: div_ratio = 1;
      3'd1: div_ratio = 4;
      3'd2: div_ratio = 16;
      3'd3: div_ratio = 32;
      3'd4: div_ratio = 64;
      3'd5: div_ratio = 128;
      3'd6: div_ratio = 1024;
      default: div_ratio = 4096;
    endcase
  endfunction
endpackage

// File: rtl/wdk_regfile.sv
module wdk_regfile
  import wdk_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CNT_W    = 16,
  parameter int BUSY_LEN = 3
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap_evt,
  output logic              en,
  output logic [2:0]        cks,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val,
  output logic              busy,
  output logic              ovf,
  output logic              acc_wr,
  output logic [BUS_W-1:0]  rdata
);
  localparam int BW = $clog2(BUSY_LEN + 1);

  logic          live;
  logic          hit_cnt, hit_csa, hit_csb;
  logic          acc_cnt, acc_csa, acc_csb;
  logic [7:0]    csb_q;
  logic [BW-1:0] busy_cnt;
  logic [7:0]    csa_view;

  assign live    = !por && !rst;
  assign hit_cnt = (addr == ADDR_W'(OFS_CNT));
  assign hit_csa = (addr == ADDR_W'(OFS_CSA));
  assign hit_csb = (addr == ADDR_W'(OFS_CSB));
  assign acc_cnt = live && we && hit_cnt && (wdata[31:16] == KEY_CNT);
  assign acc_csa = live && we && hit_csa && (wdata[31:8] == KEY_CTL);
  assign acc_csb = live && we && hit_csb && (wdata[31:8] == KEY_CTL);
  assign acc_wr  = acc_cnt || acc_csa || acc_csb;

  assign cnt_ld     = acc_cnt;
  assign cnt_ld_val = wdata[CNT_W-1:0];
  assign busy       = (busy_cnt != '0);

  always_comb begin
    csa_view         = '0;
    csa_view[B_EN]   = en;
    csa_view[B_BUSY] = busy;
    csa_view[B_OVF]  = ovf;
    csa_view[2:0]    = cks;
  end

  // system-reset domain
  always_ff @(posedge clk) begin
    if (por || rst) begin
      en       <= 1'b0;
      cks      <= '0;
      csb_q    <= '0;
      busy_cnt <= '0;
      rdata    <= '0;
    end else begin
      if (acc_csa) begin
        en  <= wdata[B_EN];
        cks <= wdata[2:0];
      end
      if (acc_csb)
        csb_q <= wdata[7:0];
      if (acc_wr)
        busy_cnt <= BW'(BUSY_LEN);
      else if (busy_cnt != '0)
        busy_cnt <= busy_cnt - 1'b1;
      case (1'b1)
        hit_cnt: rdata <= BUS_W'(cnt);
        hit_csa: rdata <= BUS_W'(csa_view);
        hit_csb: rdata <= BUS_W'(csb_q);
        default: rdata <= '0;
      endcase
    end
  end

  // power-on domain: the flag outlives the system reset
  always_ff @(posedge clk) begin
    if (por)
      ovf <= 1'b0;
    else if (wrap_evt)
      ovf <= 1'b1;
    else if (acc_csa)
      ovf <= ovf & wdata[B_OVF];
  end
endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler
  import wdk_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       restart,
  input  logic       en,
  input  logic [2:0] cks,
  output logic       tick
);
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] lim;

  assign lim  = PRE_W'(div_ratio(cks) - 1);
  assign tick = en && (phase >= lim);

  always_ff @(posedge clk) begin
    if (clr || restart)
      phase <= '0;
    else if (en)
      phase <= tick ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  assign wrap_evt = tick && (&cnt) && !ld && !clr;

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (ld)
      cnt <= ld_val;
    else if (tick)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdk_rstpulse.sv
module wdk_rstpulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic por,
  input  logic trig,
  output logic req
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    if (trig)
      left_d = PW'(PULSE_LEN);
    else if (left_q != '0)
      left_d = left_q - 1'b1;
    else
      left_d = '0;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      left_q <= '0;
      req    <= 1'b0;
    end else begin
      left_q <= left_d;
      req    <= (left_d != '0);
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdk_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 12,
  parameter int BUSY_LEN  = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              reset_req
);
  logic             en, busy, ovf, acc_wr, tick, wrap_evt, cnt_ld;
  logic [2:0]       cks;
  logic [CNT_W-1:0] cnt, cnt_ld_val;
  logic             clr;

  assign clr = por || rst;

  wdk_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUSY_LEN(BUSY_LEN)) u_regs (
    .clk(clk), .por(por), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .cnt(cnt), .wrap_evt(wrap_evt), .en(en), .cks(cks), .cnt_ld(cnt_ld),
    .cnt_ld_val(cnt_ld_val), .busy(busy), .ovf(ovf), .acc_wr(acc_wr),
    .rdata(rdata)
  );

  wdk_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .clr(clr), .restart(cnt_ld), .en(en), .cks(cks), .tick(tick)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .clr(clr), .ld(cnt_ld), .ld_val(cnt_ld_val), .tick(tick),
    .cnt(cnt), .wrap_evt(wrap_evt)
  );

  wdk_rstpulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .por(por), .trig(wrap_evt), .req(reset_req)
  );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              por,
  input logic              rst,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              en,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrap_evt,
  input logic              ovf,
  input logic              acc_wr,
  input logic              busy,
  input logic              reset_req
);
  // R9: a wrap raises the request and the flag in the next cycle
  a_r9_wrap_raises: assert property (@(posedge clk) disable iff (por || rst)
    wrap_evt |=> (reset_req && ovf));

  // R6: busy follows an accepted write and drops three quiet cycles later
  a_r6_busy_set: assert property (@(posedge clk) disable iff (por || rst)
    acc_wr |=> busy);
  a_r6_busy_clear: assert property (@(posedge clk) disable iff (por || rst)
    (!acc_wr && !$past(acc_wr) && !$past(acc_wr, 2)) |=> !busy);

  // R8: a disabled counter moves only on a keyed load
  a_r8_hold: assert property (@(posedge clk) disable iff (por || rst)
    (!en && !(we && addr == ADDR_W'(0) && wdata[31:16] == 16'h5A5A)) |=> $stable(cnt));

  // R4: a bad counter key leaves a stopped counter alone
  a_r4_bad_key: assert property (@(posedge clk) disable iff (por || rst)
    (!en && we && addr == ADDR_W'(0) && wdata[31:16] != 16'h5A5A) |=> $stable(cnt));

  // R10: the flag rises only on a wrap and falls only on an accepted write
  a_r10_ovf_src: assert property (@(posedge clk) disable iff (por)
    $rose(ovf) |-> $past(wrap_evt));
  a_r10_ovf_keep: assert property (@(posedge clk) disable iff (por)
    (ovf && !acc_wr) |=> ovf);

  // R8: no tick without enable
  a_r8_no_tick: assert property (@(posedge clk) disable iff (por || rst)
    !en |-> !tick);
endmodule

bind keyed_wdt wdk_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .por(por), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
  .en(en), .tick(tick), .cnt(cnt), .wrap_evt(wrap_evt), .ovf(ovf),
  .acc_wr(acc_wr), .busy(busy), .reset_req(reset_req)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        reset_req;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        rd_v = 1'b0;

  always #4 clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .por(por), .rst(rst), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .reset_req(reset_req)
  );

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) rd_v <= rd_req;
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rd_v) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty act=%h exp=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s rdata=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1200000;
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    idle(3);
    por = 1'b0; rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 reset_req", reset_req, 1'b0);
    rd(4'h0, 32'h0, "R1 cnt");
    rd(4'h4, 32'h0, "R1 csa");
    rd(4'h8, 32'h0, "R1 csb");
    rd(4'hC, 32'h0, "R5 unmapped");
    // R2 keyed counter load
    wr(4'h0, 32'h5A5A_1234);
    rd(4'h0, 32'h1234, "R2 load");
    // R4 wrong keys
    wr(4'h0, 32'h5A5B_FFFF);
    rd(4'h0, 32'h1234, "R4 cnt bad key");
    wr(4'h0, 32'hA5A5_A5FF);
    rd(4'h0, 32'h1234, "R4 cnt ctl key");
    wr(4'h4, 32'hA5A5_A487);
    rd(4'h4, 32'h0, "R4 csa bad key no busy");
    // R3 R6 keyed control write and busy window
    wr(4'h8, 32'hA5A5_A53C);
    rd(4'h4, 32'h20, "R6 busy 1");
    rd(4'h4, 32'h20, "R6 busy 2");
    rd(4'h4, 32'h20, "R6 busy 3");
    rd(4'h4, 32'h00, "R6 busy end");
    rd(4'h8, 32'h3C, "R11 csb readback");
    wr(4'h8, 32'hA5A5_5AFF);
    rd(4'h8, 32'h3C, "R4 csb bad key");
    // R8 hold while disabled
    wr(4'h0, 32'h5A5A_FFF0);
    idle(20);
    rd(4'h0, 32'hFFF0, "R8 hold");
    wr(4'h4, 32'hA5A5_A507);
    idle(5);
    rd(4'h4, 32'h07, "R3 R5 csa layout");
    rd(4'h0, 32'hFFF0, "R8 hold with code");
    // R9 ratio 1, 16 ticks
    wr(4'h0, 32'h5A5A_FFF0);
    wr(4'h4, 32'hA5A5_A580);
    idle(15);
    chk("R9 before wrap", reset_req, 1'b0);
    idle(1);
    chk("R9 wrap rise", reset_req, 1'b1);
    idle(15);
    chk("R9 pulse last", reset_req, 1'b1);
    idle(1);
    chk("R9 pulse end", reset_req, 1'b0);
    rd(4'h4, 32'h90, "R9 ovf set");
    wr(4'h4, 32'hA5A5_A510);
    idle(4);
    rd(4'h4, 32'h10, "R10 disable keeps ovf");
    // R10 flag survives the system reset
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd(4'h4, 32'h10, "R10 survives rst");
    rd(4'h0, 32'h0, "R1 cnt after rst");
    rd(4'h8, 32'h0, "R1 csb after rst");
    wr(4'h4, 32'hA5A5_A400);
    idle(4);
    rd(4'h4, 32'h10, "R10 bad key no clear");
    wr(4'h4, 32'hA5A5_A500);
    idle(4);
    rd(4'h4, 32'h00, "R10 keyed clear");
    wr(4'h4, 32'hA5A5_A510);
    idle(4);
    rd(4'h4, 32'h00, "R10 write one no set");
    // R7 ratio 4, 2 ticks
    wr(4'h0, 32'h5A5A_FFFE);
    wr(4'h4, 32'hA5A5_A581);
    idle(7);
    chk("R7 div4 before", reset_req, 1'b0);
    idle(1);
    chk("R7 div4 wrap", reset_req, 1'b1);
    wr(4'h4, 32'hA5A5_A501);
    idle(20);
    chk("R9 pulse over", reset_req, 1'b0);
    // R7 ratio 32, 3 ticks
    wr(4'h0, 32'h5A5A_FFFD);
    wr(4'h4, 32'hA5A5_A583);
    idle(95);
    chk("R7 div32 before", reset_req, 1'b0);
    idle(1);
    chk("R7 div32 wrap", reset_req, 1'b1);
    wr(4'h4, 32'hA5A5_A503);
    idle(20);
    // R7 ratio 4096, 1 tick
    wr(4'h0, 32'h5A5A_FFFF);
    wr(4'h4, 32'hA5A5_A587);
    idle(4095);
    chk("R7 div4096 before", reset_req, 1'b0);
    idle(1);
    chk("R7 div4096 wrap", reset_req, 1'b1);
    rd(4'h4, 32'h97, "R5 R9 csa after wrap");
    wr(4'h4, 32'hA5A5_A517);
    idle(20);
    // R10 power-on reset clears the flag
    por = 1'b1;
    idle(1);
    por = 1'b0;
    rd(4'h4, 32'h00, "R10 por clears");
    chk("R1 reset_req after por", reset_req, 1'b0);
    idle(2);
    finish_run();
  end
endmodule